// File: doc/BRIEF.md
# Countdown Timer with Masked Interrupt

A free-running countdown timer for a network controller's housekeeping. The 32-bit count is held as two 16-bit halves that software reads and writes through a small register port. While the timer runs, the count drops by one on every cycle in which the tick-enable strobe is high. The strobe is meant to arrive at 5 MHz from a divider outside the block. When a tick arrives with the count already at zero, the count wraps to all ones, counting goes on, and a timer-complete status bit is raised.

The block also holds the interrupt status register and the interrupt mask register that the timer reports through. Other event sources reach the status register through a set-vector input. Status bits are cleared by writing ones to them. The interrupt line is high while any status bit is set and also enabled in the mask.

The timer is controlled by two command bits in a control register: start and stop. Reading the low half of the count also captures the high half. A following read of the high half therefore gives a value that is consistent with the low half just read.

Top module: `wdt_timer`

Register map (word address on `addr`): 0 control, 1 status, 2 mask, 3 count low half, 4 count high half. Control bit 0 is start and bit 1 is stop. A control read returns {stop state, run state} in bits [1:0].

## Requirements
- R1: After reset the timer is stopped (control reads 0x0002), both count halves read 0, status and mask read 0, and `irq` is low.
- R2: The count is {high half, low half}. While the timer runs, each cycle with `tick_en` high lowers the count by one. While it is stopped, ticks leave the count unchanged.
- R3: A tick at count zero while running loads 0xFFFF into both halves, sets status bit 7 (0x0080) and leaves the timer running, so that counting continues.
- R4: Writing the control register with bit 0 set starts the timer and clears the stop state. Writing it with bit 1 set stops the timer and clears the run state. With both bits set, stop wins. With neither bit set, nothing changes.
- R5: A write to either count half replaces that half in the same cycle, taking precedence over a tick in that cycle. A running timer then counts down from the new 32-bit value.
- R6: A read of the low half returns the live low half and latches the live high half. A read of the high half returns the value latched by the most recent low-half read.
- R7: Mask bit 15 cannot be written and always reads 0. The other mask bits read back as written.
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0. A bit being set in the same cycle as it is cleared ends up set.
- R9: Each bit high on `evt_set` sets the matching status bit.
- R10: `irq` is high exactly when (mask AND status) is nonzero, following a register change by one cycle.
- R11: Writes to unmapped addresses 5 to 7 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count strobe, one cycle per timer tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (the read has a side effect on the low half) |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| evt_set | input | 16 | Set requests for status bits from other sources |
| rdata | output | 16 | Read data, valid in the cycle `rd_en` is high; 0 otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. They also assume that a status clear is checked only in cycles where `evt_set` is zero and the timer cannot wrap, and that `tick_en` is a single-cycle-qualified strobe with no further protocol. The stimulus drives one register access at a time, from the falling clock edge. It keeps `tick_en` low during reads and writes, except in the two directed cases that deliberately overlap a tick with a count write or a status clear. It pulses `evt_set` only when no status clear is in flight.

// File: rtl/wdt_pkg.sv
// Package: register addresses, control bit positions and status bit
// positions shared by the timer, its submodules, checker and bench.
package wdt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;

    localparam int TC_BIT = 7;
endpackage

// File: rtl/wdt_ctrl.sv
// Run/stop state machine. It assumes that cmd_wr is a single-cycle write
// strobe. When both command bits are set, stop takes precedence.
module wdt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_start,
    input  logic cmd_stop,
    output logic running,
    output logic halted
);
    logic run_q;
    logic halt_q;

    // Update the run/stop flags on command writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            halt_q <= 1'b1;
        end else if (cmd_wr && cmd_stop) begin
            run_q  <= 1'b0;
            halt_q <= 1'b1;
        end else if (cmd_wr && cmd_start) begin
            run_q  <= 1'b1;
            halt_q <= 1'b0;
        end
    end

    assign running = run_q;
    assign halted  = halt_q;
endmodule

// File: rtl/wdt_counter.sv
// Split down-counter. It holds a 2*HALF_W count, decrements on a tick while
// running and wraps to all ones with an underflow pulse. It assumes that the
// low-half and high-half writes are never both asserted in one cycle.
module wdt_counter #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                running,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count,
    output logic                underflow
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // A tick counts only while running and with no write to the count.
    assign step      = running && tick && !wr_lo && !wr_hi;
    assign underflow = step && (cnt_q == '0);

    // Load a written half, otherwise step down or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[HALF_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CNT_W-1:HALF_W] <= wdata;
        end else if (underflow) begin
            cnt_q <= '1;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdt_irq_regs.sv
// Interrupt status register (write-one-to-clear, set wins) and mask
// register with the top bit tied low. The request output is registered-state
// combinational: it follows a register change by one cycle.
module wdt_irq_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stat_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] clr_vec;

    assign clr_vec = stat_wr ? wdata : '0;

    // Status: clear the ones written, then apply new set requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    // Mask: the top bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= {1'b0, wdata[W-2:0]};
        end
    end

    assign status = stat_q;
    assign mask   = mask_q;
    assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/wdt_timer.sv
// Top level of the countdown timer. It decodes register accesses, muxes
// read data and keeps the high-half snapshot for coherent paired reads.
// It assumes that wr_en and rd_en are never high in the same cycle.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] evt_set,
    output logic [HALF_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic              run_w;
    logic              halt_w;
    logic [CNT_W-1:0]  count_w;
    logic              uflow_w;
    logic [HALF_W-1:0] status_w;
    logic [HALF_W-1:0] mask_w;
    logic [HALF_W-1:0] set_w;
    logic [HALF_W-1:0] hi_snap_q;

    logic wr_ctrl, wr_stat, wr_mask, wr_lo, wr_hi, rd_lo;

    // Write decode.
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_stat = wr_en && (addr == A_STATUS);
        wr_mask = wr_en && (addr == A_MASK);
        wr_lo   = wr_en && (addr == A_CNT_LO);
        wr_hi   = wr_en && (addr == A_CNT_HI);
        rd_lo   = rd_en && (addr == A_CNT_LO);
    end

    wdt_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (wr_ctrl),
        .cmd_start (wdata[CMD_START]),
        .cmd_stop  (wdata[CMD_STOP]),
        .running   (run_w),
        .halted    (halt_w)
    );

    wdt_counter #(.HALF_W(HALF_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (run_w),
        .tick      (tick_en),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (wdata),
        .count     (count_w),
        .underflow (uflow_w)
    );

    // Merge the timer-complete event into the external set requests.
    always_comb begin
        set_w         = evt_set;
        set_w[TC_BIT] = evt_set[TC_BIT] | uflow_w;
    end

    wdt_irq_regs #(.W(HALF_W)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (wr_stat),
        .mask_wr (wr_mask),
        .wdata   (wdata),
        .set_vec (set_w),
        .status  (status_w),
        .mask    (mask_w),
        .irq     (irq)
    );

    // Capture the high half whenever the low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_snap_q <= '0;
        end else if (rd_lo) begin
            hi_snap_q <= count_w[CNT_W-1:HALF_W];
        end
    end

    // Read data multiplexer; zero outside read cycles and unmapped addresses.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:   rdata = {{(HALF_W-2){1'b0}}, halt_w, run_w};
                A_STATUS: rdata = status_w;
                A_MASK:   rdata = mask_w;
                A_CNT_LO: rdata = count_w[HALF_W-1:0];
                A_CNT_HI: rdata = hi_snap_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_timer_chk.sv
// Property checker for wdt_timer. It is attached by bind and observes the
// port-level accesses together with the count, run state and interrupt
// registers.
module wdt_timer_chk
    import wdt_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [HALF_W-1:0]   wdata,
    input logic [HALF_W-1:0]   evt_set,
    input logic [2*HALF_W-1:0] count,
    input logic                running,
    input logic [HALF_W-1:0]   status,
    input logic [HALF_W-1:0]   mask,
    input logic                irq
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !cnt_wr && count != '0)
        |=> (count == $past(count) - 1'b1));

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(count));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !cnt_wr && count == '0)
        |=> (count == '1 && status[TC_BIT] && running));

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && wdata[CMD_STOP]) |=> !running);

    // R5
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CNT_LO) |=> (count[HALF_W-1:0] == $past(wdata)));

    // R7
    mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask[HALF_W-1]);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATUS && wdata == '1 && evt_set == '0 && !running)
        |=> !irq);
endmodule

bind wdt_timer wdt_timer_chk #(.HALF_W(HALF_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .evt_set (evt_set),
    .count   (count_w),
    .running (run_w),
    .status  (status_w),
    .mask    (mask_w),
    .irq     (irq)
);

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
    import wdt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] evt_set = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wdt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .evt_set(evt_set),
        .rdata(rdata), .irq(irq)
    );

    // Entry: {op[1:0], addr[2:0], data[15:0], expect[15:0]}; op 1 write, 2 read.
    localparam int NV = 14;
    localparam logic [36:0] TBL [0:NV-1] = '{
        {2'd1, 3'd2, 16'h8001, 16'h0000},  // R7 write mask with bit 15
        {2'd2, 3'd2, 16'h0000, 16'h0001},  // R7 bit 15 reads 0
        {2'd1, 3'd3, 16'h1234, 16'h0000},  // R5 load low half
        {2'd1, 3'd4, 16'hABCD, 16'h0000},  // R5 load high half
        {2'd2, 3'd3, 16'h0000, 16'h1234},  // R6 low read latches high
        {2'd2, 3'd4, 16'h0000, 16'hABCD},  // R6 high read from latch
        {2'd2, 3'd0, 16'h0000, 16'h0002},  // R1 stopped
        {2'd1, 3'd0, 16'h0001, 16'h0000},  // R4 start
        {2'd2, 3'd0, 16'h0000, 16'h0001},  // R4 running, stop cleared
        {2'd1, 3'd0, 16'h0003, 16'h0000},  // R4 start and stop together
        {2'd2, 3'd0, 16'h0000, 16'h0002},  // R4 stop wins
        {2'd1, 3'd0, 16'h0000, 16'h0000},  // R4 no command bits
        {2'd2, 3'd0, 16'h0000, 16'h0002},  // R4 unchanged
        {2'd1, 3'd2, 16'h0000, 16'h0000}   // clear mask
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {15'b0, irq}, 16'h0000);
        rd(A_CTRL,   16'h0002, "R1 ctrl");
        rd(A_CNT_LO, 16'h0000, "R1 lo");
        rd(A_CNT_HI, 16'h0000, "R1 hi");
        rd(A_STATUS, 16'h0000, "R1 status");
        rd(A_MASK,   16'h0000, "R1 mask");

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][36:35] == 2'd1) wr(TBL[i][34:32], TBL[i][31:16]);
            else rd(TBL[i][34:32], TBL[i][15:0], "table");
        end

        // R2 countdown while running
        wr(A_CNT_LO, 16'd5); wr(A_CNT_HI, 16'd0); wr(A_CTRL, 16'h0001);
        ticks(3);
        rd(A_CNT_LO, 16'd2, "R2 after three ticks");
        rd(A_CNT_HI, 16'd0, "R2 high");
        // R2 ticks ignored when stopped
        wr(A_CTRL, 16'h0002);
        ticks(4);
        rd(A_CNT_LO, 16'd2, "R2 stopped hold");

        // R3 underflow
        wr(A_CNT_LO, 16'd1); wr(A_CTRL, 16'h0001);
        ticks(1);
        rd(A_STATUS, 16'h0000, "R3 no flag before wrap");
        ticks(1);
        rd(A_CNT_LO, 16'hFFFF, "R3 wrap low");
        rd(A_CNT_HI, 16'hFFFF, "R3 wrap high");
        rd(A_STATUS, 16'h0080, "R3 flag");
        rd(A_CTRL,   16'h0001, "R3 still running");
        ticks(1);
        rd(A_CNT_LO, 16'hFFFE, "R3 keeps counting");

        // R10 / R8 interrupt and clear
        check("R10 irq masked", {15'b0, irq}, 16'h0000);
        wr(A_MASK, 16'h0080);
        check("R10 irq raised", {15'b0, irq}, 16'h0001);
        wr(A_STATUS, 16'h0000);
        check("R8 zero write keeps", {15'b0, irq}, 16'h0001);
        wr(A_STATUS, 16'h0080);
        check("R8 cleared irq", {15'b0, irq}, 16'h0000);
        rd(A_STATUS, 16'h0000, "R8 cleared");

        // R5 write beats tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = A_CNT_LO; wdata = 16'h0010;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd(A_CNT_LO, 16'h0010, "R5 write over tick");
        ticks(1);
        rd(A_CNT_LO, 16'h000F, "R5 counts from new value");

        // R8 set wins over a simultaneous clear
        wr(A_CNT_LO, 16'd0); wr(A_CNT_HI, 16'd0);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = A_STATUS; wdata = 16'h0080;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd(A_STATUS, 16'h0080, "R8 set wins");
        wr(A_STATUS, 16'hFFFF);

        // R6 coherent paired read
        wr(A_CNT_HI, 16'h0002); wr(A_CNT_LO, 16'h0000);
        ticks(1);
        rd(A_CNT_LO, 16'hFFFF, "R6 live low");
        wr(A_CNT_HI, 16'h0007);
        rd(A_CNT_HI, 16'h0001, "R6 latched high");
        rd(A_CNT_LO, 16'hFFFF, "R6 low again");
        rd(A_CNT_HI, 16'h0007, "R6 new latch");

        // R9 external set request
        wr(A_CTRL, 16'h0002);
        wr(A_MASK, 16'h0100);
        @(negedge clk); evt_set = 16'h0100;
        @(negedge clk); evt_set = 16'h0000;
        check("R9 irq from event", {15'b0, irq}, 16'h0001);
        rd(A_STATUS, 16'h0100, "R9 status");

        // R11 unmapped address
        wr(3'd7, 16'hFFFF);
        rd(3'd7, 16'h0000, "R11 read zero");
        rd(A_MASK, 16'h0100, "R11 mask untouched");
        rd(A_STATUS, 16'h0100, "R11 status untouched");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule